// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block slows the core clock down for use off the chip. It holds one 16-bit control register that sits on a simple port-mapped bus, and a counter that turns the core clock into a slower square wave. A 3-bit select field in the register picks the divide ratio. The three smallest bits are the only ones that hold state. Code 000 means no division at all. Codes 001 to 111 give twice the code value: 2, 4, 6, 8, 10, 12 and 14. Changing this field touches nothing except the output divider.

The divider drives three outputs, all of them registered:
- `div_wave` is a 50% duty square wave for the even ratios.
- `div_pulse` is high for one cycle at the start of each output period.
- `div_bypass` tells a downstream clock mux to pass the core clock straight through when the ratio is 1.

A newly written ratio takes effect only when the current output period ends. The period that is running always finishes at its old length and duty, so no output phase is ever cut short.

Top module: `clkout_divider`

## Requirements
- R1: After a synchronous active-high reset:
  - the select field is 000 and a read of the register returns 0x0000;
  - `div_bypass`, `div_wave` and `div_pulse` are all 1.
- R2: The register answers only at port address 0x07FD. A read strobe there returns the current register contents on `bus_rdata` in the next cycle. `bus_rdata` holds that value until the next read strobe.
- R3: Bits 15 to 3 of the register ignore writes and always read as 0. The select field sits in bits 2 to 0 and can be written and read back.
- R4: The select code maps to these divide ratios:

  | Code | Ratio |
  |------|-------|
  | 000 | 1 |
  | 001 | 2 |
  | 010 | 4 |
  | 011 | 6 |
  | 100 | 8 |
  | 101 | 10 |
  | 110 | 12 |
  | 111 | 14 |

- R5: With ratio 1:
  - `div_bypass` is 1;
  - `div_wave` stays at 1;
  - `div_pulse` is 1 in every cycle.
- R6: With an even ratio N:
  - `div_pulse` is 1 for exactly one cycle out of every N;
  - `div_wave` is 1 in the pulse cycle and the N/2-1 cycles after it, and 0 in the remaining N/2 cycles;
  - `div_bypass` is 0.
- R7: A ratio written in the middle of an output period does not change that period's length or high time. The new ratio governs the period that starts at the next `div_pulse`.
- R8: A write to any other address leaves the register unchanged. A read strobe at any other address returns 0x0000 on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Port address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| div_wave | output | 1 | Divided square wave |
| div_pulse | output | 1 | One-cycle marker at the start of each output period |
| div_bypass | output | 1 | High when the ratio is 1 and the core clock should pass through |

## Verification
The assertions check several properties on every cycle:
- the period counter stays below the active ratio;
- the active ratio changes only on the last cycle of a period;
- every period starts with the wave high, and bypass implies a steady high wave with a pulse;
- foreign writes never move the select field;
- read data follows a read strobe one cycle later.

Other behaviours appear only in the bench's scenarios:
- the exact period length and high time for each of the eight codes;
- the full code-to-ratio mapping;
- a ratio change in the middle of a period leaving that period untouched while the following one takes the new length.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
  parameter int          ADDR_W   = 16;
  parameter int          DATA_W   = 16;
  parameter int          SEL_W    = 3;
  parameter logic [15:0] REG_ADDR = 16'h07FD;

  // Largest ratio is 2*(2**SEL_W - 1); width to hold it.
  function automatic int ratio_width(input int sel_w);
    return $clog2(2 * ((1 << sel_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/cdv_regfile.sv
module cdv_regfile #(
  parameter int               ADDR_W   = 16,
  parameter int               DATA_W   = 16,
  parameter int               SEL_W    = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h07FD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  sel
);
  logic              hit;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] view;

  assign hit  = (addr == REG_ADDR);
  // Reserved upper bits hold no state and read as zero.
  assign view = DATA_W'(sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && hit) sel_q <= wdata[SEL_W-1:0];
      if (rd) rdata_q <= hit ? view : '0;
    end
  end

  assign rdata = rdata_q;
  assign sel   = sel_q;

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> $stable(sel_q)); // R8
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit) |=> (rdata_q == '0)); // R8
  AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (rd && hit) |=> (rdata_q == DATA_W'($past(sel_q)))); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd && !$past(rst)) |=> $stable(rdata_q)); // R2
endmodule

// File: rtl/cdv_ratio_map.sv
module cdv_ratio_map #(
  parameter int SEL_W   = 3,
  parameter int RATIO_W = 4
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [RATIO_W-1:0] ratio
);
  // Code 0 is pass-through; every other code divides by twice its value.
  always_comb begin
    if (sel == '0) ratio = RATIO_W'(1);
    else           ratio = RATIO_W'({sel, 1'b0});
  end
endmodule

// File: rtl/cdv_divider.sv
module cdv_divider #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] req_ratio,
  output logic               wave,
  output logic               pulse,
  output logic               bypass
);
  logic [RATIO_W-1:0] cnt_q, act_q, cnt_nx, act_nx, half_nx;
  logic               last;
  logic               wave_q, pulse_q, bypass_q;

  always_comb begin
    last    = (cnt_q == act_q - RATIO_W'(1));
    cnt_nx  = last ? '0 : cnt_q + RATIO_W'(1);
    act_nx  = last ? req_ratio : act_q;   // ratio switches only at a period edge
    half_nx = act_nx >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      act_q    <= RATIO_W'(1);
      wave_q   <= 1'b1;
      pulse_q  <= 1'b1;
      bypass_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nx;
      act_q    <= act_nx;
      pulse_q  <= (cnt_nx == '0);
      bypass_q <= (act_nx == RATIO_W'(1));
      wave_q   <= (act_nx == RATIO_W'(1)) || (cnt_nx < half_nx);
    end
  end

  assign wave   = wave_q;
  assign pulse  = pulse_q;
  assign bypass = bypass_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < act_q); // R6
  AST_RATIO_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(act_q)); // R7
  AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> wave_q); // R6
  AST_BYPASS_STEADY: assert property (@(posedge clk) disable iff (rst)
    bypass_q |-> (wave_q && pulse_q)); // R5
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import cdv_pkg::*;
#(
  parameter int               P_ADDR_W   = ADDR_W,
  parameter int               P_DATA_W   = DATA_W,
  parameter int               P_SEL_W    = SEL_W,
  parameter logic [P_ADDR_W-1:0] P_REG_ADDR = REG_ADDR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  output logic                div_wave,
  output logic                div_pulse,
  output logic                div_bypass
);
  localparam int RW = ratio_width(P_SEL_W);

  logic [P_SEL_W-1:0] sel;
  logic [RW-1:0]      ratio;

  cdv_regfile #(
    .ADDR_W(P_ADDR_W), .DATA_W(P_DATA_W), .SEL_W(P_SEL_W), .REG_ADDR(P_REG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .sel(sel)
  );

  cdv_ratio_map #(.SEL_W(P_SEL_W), .RATIO_W(RW)) u_map (
    .sel(sel), .ratio(ratio)
  );

  cdv_divider #(.RATIO_W(RW)) u_div (
    .clk(clk), .rst(rst), .req_ratio(ratio),
    .wave(div_wave), .pulse(div_pulse), .bypass(div_bypass)
  );
endmodule

// File: tb/tb_clkout_divider.sv
module tb_clkout_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        div_wave, div_pulse, div_bypass;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [15:0] REG = 16'h07FD;
  // code -> expected ratio (R4)
  localparam int EXP_N [8] = '{1, 2, 4, 6, 8, 10, 12, 14};

  always #5 clk = ~clk;

  clkout_divider dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_wave(div_wave),
    .div_pulse(div_pulse), .div_bypass(div_bypass)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_pulse();
    @(negedge clk);
    while (!div_pulse) @(negedge clk);
  endtask

  // Called at a negedge where div_pulse is high; returns at the next one.
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      len++;
      if (div_wave) hi++;
      @(negedge clk);
    end while (!div_pulse && len < 64);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int len, hi, p1, h1, p2, h2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 bypass", int'(div_bypass), 1);
    check("R1 wave", int'(div_wave), 1);
    bus_read(REG, rd);
    check("R1 readback", int'(rd), 0);

    // Table walk over all codes: R2 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      bus_write(REG, 16'(i));
      bus_read(REG, rd);
      check("R2 readback", int'(rd), i);
      wait_pulse();
      measure(len, hi);           // may still be the old ratio
      measure(len, hi);
      check("R4 period", len, EXP_N[i]);
      check("R6 high time", hi, (EXP_N[i] == 1) ? 1 : EXP_N[i] / 2);
      check("R5 bypass", int'(div_bypass), (EXP_N[i] == 1) ? 1 : 0);
    end

    // R3 reserved bits
    bus_write(REG, 16'hFFFA);
    bus_read(REG, rd);
    check("R3 reserved", int'(rd), 16'h0002);

    // R8 foreign address
    bus_write(16'h07FC, 16'h0005);
    bus_read(REG, rd);
    check("R8 write ignored", int'(rd), 2);
    bus_read(16'h07FE, rd);
    check("R8 foreign read", int'(rd), 0);

    // R7 change mid-period: 14 -> 2
    bus_write(REG, 16'h0007);
    wait_pulse(); measure(len, hi); measure(len, hi);
    fork
      begin measure(p1, h1); measure(p2, h2); end
      begin repeat (3) @(negedge clk); bus_write(REG, 16'h0001); end
    join
    check("R7 old period", p1, 14);
    check("R7 old high", h1, 7);
    check("R7 new period", p2, 2);
    check("R7 new high", h2, 1);

    // R7 change mid-period: 4 -> 12
    bus_write(REG, 16'h0002);
    wait_pulse(); measure(len, hi); measure(len, hi);
    fork
      begin measure(p1, h1); measure(p2, h2); end
      begin bus_write(REG, 16'h0006); end
    join
    check("R7 short old period", p1, 4);
    check("R7 short old high", h1, 2);
    check("R7 long new period", p2, 12);
    check("R7 long new high", h2, 6);

    // R1 reset while running
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 bypass after reset", int'(div_bypass), 1);
    bus_read(REG, rd);
    check("R1 field after reset", int'(rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule